// File: doc/BRIEF.md
# Ramp Reference Comparator Trip Latch

This block stands in for the negative reference of an analog comparator by producing a falling digital ramp. It compares that ramp against a sampled digital value of the positive input. Software stages three settings in shadow registers: a start level, a step size and a hold time. All three are clamped to their legal range when they are written. A synchronization pulse copies the shadow settings into the working registers. The ramp then restarts at the start level, holds for the hold time, and falls by the step on every following clock until it reaches zero.

The compare result is registered and feeds a sticky trip flag. The flag stays set until software strobes a clear or the next synchronization pulse arrives. If a clear and a set come in the same cycle, the clear takes priority.

Settings enter through a valid/ready write port. A write is taken on a clock edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` drops for exactly the cycle in which `sync_i` is high, so a shadow write can never race a reload. A writer holds `cfg_valid` and its data stable until the write is accepted. All other pins are plain level or strobe signals.

Top module: `ramp_trip_comparator`

## Requirements
- R1: After reset `ramp_o`, `cmp_o` and `trip_o` are 0, `cfg_ready` is 1, and the ramp stays at 0 until the first `sync_i`.
- R2: A write is accepted only when `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is the inverse of `sync_i`. Accepted settings change `ramp_o` only after a later `sync_i`.
- R3: A start level request above 65535 is stored as 65535.
- R4: A step request above 65535 is stored as 65535.
- R5: A hold time request above 8192 is stored as 8192.
- R6: On the cycle after a `sync_i` edge, `ramp_o` equals the shadow start level that was present at that edge. It keeps that value for hold+1 cycles.
- R7: After the hold, `ramp_o` falls by the step on each clock. It stops at 0 and never wraps. Between sync pulses `ramp_o` never rises.
- R8: `cmp_o` is 1 in the cycle after an edge where `pos_i` > `ramp_o`, and is 0 otherwise.
- R9: `trip_o` becomes 1 in the cycle after `cmp_o` is 1. It then stays 1 until it is cleared.
- R10: A nonzero `clr_i`, or `sync_i`, at an edge makes `trip_o` 0 in the next cycle, even when `cmp_o` is 1. If the compare stays true, the flag sets again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Settings write request |
| cfg_ready | output | 1 | Write can be taken (low during sync) |
| cfg_ref | input | 20 | Requested start level, clamped to 65535 |
| cfg_dec | input | 20 | Requested step, clamped to 65535 |
| cfg_dly | input | 16 | Requested hold time in cycles, clamped to 8192 |
| sync_i | input | 1 | Reload pulse; also clears the trip flag |
| pos_i | input | 16 | Sampled positive comparator input |
| clr_i | input | 4 | Software clear; any nonzero value clears |
| ramp_o | output | 16 | Current ramp reference level |
| cmp_o | output | 1 | Registered raw compare result |
| trip_o | output | 1 | Latched trip flag |

## Verification
Directed patterns cover the following cases:
- Oversized requests, which show whether each field clamps on its own.
- A long clamped hold, which tells an exact hold+1 plateau apart from an off-by-one.
- A step that overshoots zero, which tells flooring apart from wrap-around.
- A write offered in the sync cycle, which shows whether back-pressure really drops it.
- A clear held against a true compare, which separates clear priority from set priority and shows the re-set one cycle later.

A seeded random phase then mixes sync pulses, writes, clears and positive input levels against a cycle model.

// File: rtl/ramp_cmp_pkg.sv
package ramp_cmp_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_HOLD = 2'd1,
    RS_FALL = 2'd2
  } ramp_state_e;
endpackage

// File: rtl/ramp_sat.sv
module ramp_sat #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 16,
  parameter int MAX   = 65535
) (
  input  logic [IN_W-1:0]  req,
  output logic [OUT_W-1:0] sat
);
  localparam logic [IN_W-1:0] LIMIT = IN_W'(MAX);

  always_comb begin
    if (req > LIMIT) sat = OUT_W'(MAX);
    else             sat = req[OUT_W-1:0];
  end
endmodule

// File: rtl/ramp_cfg_shadow.sv
module ramp_cfg_shadow #(
  parameter int REF_W   = 16,
  parameter int REQ_W   = 20,
  parameter int DREQ_W  = 16,
  parameter int DLY_MAX = 8192,
  parameter int DLY_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              sync_i,
  input  logic [REQ_W-1:0]  cfg_ref,
  input  logic [REQ_W-1:0]  cfg_dec,
  input  logic [DREQ_W-1:0] cfg_dly,
  output logic              cfg_ready,
  output logic [REF_W-1:0]  shd_ref,
  output logic [REF_W-1:0]  shd_dec,
  output logic [DLY_W-1:0]  shd_dly
);
  localparam int REF_MAX = (1 << REF_W) - 1;

  logic [REF_W-1:0] ref_c, dec_c;
  logic [DLY_W-1:0] dly_c;
  logic             take;

  ramp_sat #(.IN_W(REQ_W),  .OUT_W(REF_W), .MAX(REF_MAX)) u_sat_ref (.req(cfg_ref), .sat(ref_c));
  ramp_sat #(.IN_W(REQ_W),  .OUT_W(REF_W), .MAX(REF_MAX)) u_sat_dec (.req(cfg_dec), .sat(dec_c));
  ramp_sat #(.IN_W(DREQ_W), .OUT_W(DLY_W), .MAX(DLY_MAX)) u_sat_dly (.req(cfg_dly), .sat(dly_c));

  assign cfg_ready = ~sync_i;
  assign take      = cfg_valid & cfg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_ref <= '0;
      shd_dec <= '0;
      shd_dly <= '0;
    end else if (take) begin
      shd_ref <= ref_c;
      shd_dec <= dec_c;
      shd_dly <= dly_c;
    end
  end
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen
  import ramp_cmp_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int DLY_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [REF_W-1:0] shd_ref,
  input  logic [REF_W-1:0] shd_dec,
  input  logic [DLY_W-1:0] shd_dly,
  output logic [REF_W-1:0] ramp_q
);
  ramp_state_e      st_q;
  logic [REF_W-1:0] dec_q;
  logic [DLY_W-1:0] cnt_q;
  logic [REF_W-1:0] ramp_step;

  // floor at zero instead of wrapping
  always_comb begin
    if (ramp_q > dec_q) ramp_step = ramp_q - dec_q;
    else                ramp_step = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      ramp_q <= '0;
      dec_q  <= '0;
      cnt_q  <= '0;
    end else if (sync_i) begin
      st_q   <= RS_HOLD;
      ramp_q <= shd_ref;
      dec_q  <= shd_dec;
      cnt_q  <= shd_dly;
    end else begin
      unique case (st_q)
        RS_HOLD: begin
          if (cnt_q == '0) begin
            st_q   <= RS_FALL;
            ramp_q <= ramp_step;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RS_FALL: ramp_q <= ramp_step;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trip_latch.sv
module trip_latch #(
  parameter int REF_W = 16,
  parameter int CLR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [CLR_W-1:0] clr_i,
  input  logic [REF_W-1:0] pos_i,
  input  logic [REF_W-1:0] ramp_q,
  output logic             cmp_q,
  output logic             trip_q
);
  logic wipe;
  assign wipe = sync_i | (|clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      cmp_q <= (pos_i > ramp_q);
      if (wipe)       trip_q <= 1'b0;
      else if (cmp_q) trip_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ramp_trip_comparator.sv
module ramp_trip_comparator #(
  parameter int REF_W   = 16,
  parameter int REQ_W   = 20,
  parameter int DREQ_W  = 16,
  parameter int DLY_MAX = 8192,
  parameter int CLR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [REQ_W-1:0]  cfg_ref,
  input  logic [REQ_W-1:0]  cfg_dec,
  input  logic [DREQ_W-1:0] cfg_dly,
  input  logic              sync_i,
  input  logic [REF_W-1:0]  pos_i,
  input  logic [CLR_W-1:0]  clr_i,
  output logic [REF_W-1:0]  ramp_o,
  output logic              cmp_o,
  output logic              trip_o
);
  localparam int DLY_W = $clog2(DLY_MAX + 1);

  logic [REF_W-1:0] shd_ref, shd_dec;
  logic [DLY_W-1:0] shd_dly;

  ramp_cfg_shadow #(
    .REF_W(REF_W), .REQ_W(REQ_W), .DREQ_W(DREQ_W),
    .DLY_MAX(DLY_MAX), .DLY_W(DLY_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .sync_i(sync_i),
    .cfg_ref(cfg_ref), .cfg_dec(cfg_dec), .cfg_dly(cfg_dly),
    .cfg_ready(cfg_ready), .shd_ref(shd_ref), .shd_dec(shd_dec), .shd_dly(shd_dly)
  );

  ramp_gen #(.REF_W(REF_W), .DLY_W(DLY_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .shd_ref(shd_ref), .shd_dec(shd_dec), .shd_dly(shd_dly),
    .ramp_q(ramp_o)
  );

  trip_latch #(.REF_W(REF_W), .CLR_W(CLR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .clr_i(clr_i),
    .pos_i(pos_i), .ramp_q(ramp_o), .cmp_q(cmp_o), .trip_q(trip_o)
  );
endmodule

// File: rtl/ramp_trip_comparator_chk.sv
module ramp_trip_comparator_chk #(
  parameter int REF_W = 16,
  parameter int CLR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_i,
  input logic             cfg_ready,
  input logic [CLR_W-1:0] clr_i,
  input logic [REF_W-1:0] shd_ref,
  input logic [REF_W-1:0] ramp_o,
  input logic             cmp_o,
  input logic             trip_o
);
  // R2
  ready_low_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> !cfg_ready);

  // R6
  reload_from_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> ramp_o == $past(shd_ref));

  // R7
  ramp_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> ramp_o <= $past(ramp_o));

  // R9
  trip_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_o && !sync_i && clr_i == '0) |=> trip_o);

  // R9
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && !sync_i && clr_i == '0) |=> trip_o);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i || clr_i != '0) |=> !trip_o);
endmodule

bind ramp_trip_comparator ramp_trip_comparator_chk #(.REF_W(REF_W), .CLR_W(CLR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cfg_ready(cfg_ready), .clr_i(clr_i),
  .shd_ref(shd_ref), .ramp_o(ramp_o), .cmp_o(cmp_o), .trip_o(trip_o)
);

// File: tb/ramp_trip_comparator_test.sv
module ramp_trip_comparator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [19:0] cfg_ref = '0;
  logic [19:0] cfg_dec = '0;
  logic [15:0] cfg_dly = '0;
  logic        sync_i = 1'b0;
  logic [15:0] pos_i = '0;
  logic [3:0]  clr_i = '0;
  logic [15:0] ramp_o;
  logic        cmp_o, trip_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // bench model state
  int unsigned m_sref, m_sdec, m_sdly;
  int unsigned m_dec, m_cnt, m_ramp;
  bit m_run, m_cmp, m_trip;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_trip_comparator uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_ref(cfg_ref), .cfg_dec(cfg_dec), .cfg_dly(cfg_dly), .sync_i(sync_i),
    .pos_i(pos_i), .clr_i(clr_i), .ramp_o(ramp_o), .cmp_o(cmp_o), .trip_o(trip_o)
  );

  function automatic int unsigned clampv(int unsigned v, int unsigned mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic int unsigned fall(int unsigned r, int unsigned d);
    return (r > d) ? r - d : 0;
  endfunction

  task automatic chk(string req, int unsigned got, int unsigned exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sref = 0; m_sdec = 0; m_sdly = 0; m_dec = 0; m_cnt = 0; m_ramp = 0;
    m_run = 0; m_cmp = 0; m_trip = 0;
  endtask

  task automatic model_edge();
    int unsigned o_ramp = m_ramp;
    bit o_cmp = m_cmp;
    bit wipe = sync_i || (clr_i != 0);
    if (sync_i) begin
      m_ramp = m_sref; m_dec = m_sdec; m_cnt = m_sdly; m_run = 1;
    end else if (m_run) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else m_ramp = fall(m_ramp, m_dec);
    end
    m_cmp = (int'(pos_i) > int'(o_ramp));
    if (wipe) m_trip = 0;
    else if (o_cmp) m_trip = 1;
    if (cfg_valid && !sync_i) begin
      m_sref = clampv(cfg_ref, 65535);
      m_sdec = clampv(cfg_dec, 65535);
      m_sdly = clampv(cfg_dly, 8192);
    end
  endtask

  // one clock: check handshake, advance model, then compare outputs
  task automatic tick();
    #1;
    chk("R2 cfg_ready", cfg_ready, !sync_i);
    @(posedge clk);
    model_edge();
    #1;
    chk("R7 ramp_o", ramp_o, m_ramp);
    chk("R8 cmp_o", cmp_o, m_cmp);
    chk("R9 trip_o", trip_o, m_trip);
  endtask

  task automatic write_cfg(int unsigned r, int unsigned d, int unsigned dl);
    cfg_valid = 1; cfg_ref = 20'(r); cfg_dec = 20'(d); cfg_dly = 16'(dl);
    tick();
    cfg_valid = 0;
  endtask

  task automatic pulse_sync();
    sync_i = 1; tick(); sync_i = 0;
  endtask

  initial begin
    int plateau;
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1 ramp after reset", ramp_o, 0);
    chk("R1 cmp after reset", cmp_o, 0);
    chk("R1 trip after reset", trip_o, 0);
    chk("R1 ready after reset", cfg_ready, 1);
    pos_i = 0;
    repeat (3) tick();
    chk("R1 ramp idle before sync", ramp_o, 0);

    // R3: oversized start level clamps; R6 plateau of hold+1
    write_cfg(70000, 3, 2);
    chk("R2 no effect before sync", ramp_o, 0);
    pulse_sync();
    chk("R3 start level clamped", ramp_o, 65535);
    tick(); tick();
    chk("R6 still holding", ramp_o, 65535);
    tick();
    chk("R7 first step", ramp_o, 65532);

    // R4: oversized step clamps, floors to zero in one step
    write_cfg(500, 100000, 0);
    pulse_sync();
    chk("R6 reload 500", ramp_o, 500);
    tick();
    chk("R4 step clamped floor", ramp_o, 0);

    // R2: write offered during sync is refused
    cfg_valid = 1; cfg_ref = 1234; cfg_dec = 1; cfg_dly = 0;
    sync_i = 1;
    #1;
    chk("R2 ready low in sync", cfg_ready, 0);
    tick();
    sync_i = 0; cfg_valid = 0;
    chk("R2 sync used old shadow", ramp_o, 500);
    pulse_sync();
    chk("R2 refused write dropped", ramp_o, 500);

    // R7: floor without wrap
    write_cfg(10, 4, 0);
    pulse_sync();
    chk("R7 start 10", ramp_o, 10);
    tick(); chk("R7 step 6", ramp_o, 6);
    tick(); chk("R7 step 2", ramp_o, 2);
    tick(); chk("R7 floor 0", ramp_o, 0);
    tick(); chk("R7 stays 0", ramp_o, 0);

    // R5: oversized hold clamps to 8192 -> 8193 cycles at level
    write_cfg(1000, 1, 9000);
    pulse_sync();
    plateau = 0;
    while (ramp_o == 1000 && plateau < 9000) begin
      plateau++;
      tick();
    end
    chk("R5 hold plateau length", plateau, 8193);
    chk("R7 after hold", ramp_o, 999);

    // R10: clear wins against true compare, then sets again
    pos_i = 16'hFFFF;
    tick(); tick();
    chk("R9 tripped", trip_o, 1);
    clr_i = 4'd2;
    tick();
    clr_i = 0;
    chk("R10 software clear wins", trip_o, 0);
    tick();
    chk("R10 sets again", trip_o, 1);
    pulse_sync();
    chk("R10 sync clears", trip_o, 0);
    tick();
    chk("R10 sets again after sync", trip_o, 1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      sync_i = (r < 4);
      cfg_valid = ($urandom_range(0, 9) == 0);
      cfg_ref = 20'($urandom_range(0, 80000));
      cfg_dec = 20'($urandom_range(0, 3) == 0 ? $urandom_range(0, 70000) : $urandom_range(0, 300));
      cfg_dly = 16'($urandom_range(0, 12));
      clr_i = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
      pos_i = 16'($urandom);
      tick();
    end
    sync_i = 0; cfg_valid = 0; clr_i = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule